// File: doc/BRIEF.md
# Six-Output Motor-Control PWM Generator

This block drives six PWM pins from one shared 12-bit period counter. The counter advances once per prescaled tick. It runs in one of two shapes. In edge-aligned mode it ramps up and wraps to zero. In center-aligned mode it ramps up to the reload value and then back down to zero. Each pin has a signed 16-bit duty value, and the pin is on while the unsigned count is below that duty value. A duty of zero or below keeps the pin off for the whole period. A duty above the reload value keeps the pin on for the whole period.

The six pins form three pairs, each with a high side and a low side. A control bit sets how the pairs work:
- **Independent mode:** every pin follows its own duty value.
- **Complementary mode:** only the high-side duty of each pair is used. The low pin is the opposite of the high pin, and a programmable dead-band holds both pins off around every switch.

A per-pair polarity bit chooses which side of the pair is on at the start of a period. Software writes every setting through a single-cycle write port. Reload and duty writes are held in a shadow copy until the count returns to zero, so a period in progress is never cut short.

Top module: `mcpwm_core`

## Requirements
- R1: After reset all six pins are low, the count is 0, and every register is zero. This means independent mode, edge-aligned mode, divide-by-1, reload 0 and all duties 0.
- R2: With control bit 0 clear (edge-aligned), the count goes 0,1,…,RELOAD-1 and then wraps to 0, so the period is RELOAD ticks. A pin is on while count < duty. At each tick a pin takes the compare result of the count held before that tick, so pins follow the count one tick late.
- R3: With control bit 0 set (center-aligned), the count rises from 0 to RELOAD and falls back through 1 to 0, so the period is 2×RELOAD ticks. A pin is on while count < duty, which gives a pulse centred on count 0.
- R4: Duty values are 16-bit two's complement with bit 15 as the sign. Any value ≤ 0, including 0x8000, keeps the pin off for the whole period. Any value greater than the active reload keeps it on for the whole period.
- R5: With control bit 1 clear (independent), pair p's high pin uses the duty at address 4+2p and its low pin uses the duty at address 5+2p.
- R6: With control bit 1 set (complementary), pair p is driven only by the high-side duty (address 4+2p). The low pin is on when the high pin would be off. Low-side duty registers have no effect.
- R7: In complementary mode, the dead-band value DB is at address 3. After every change of a pair's wanted state, both pins of that pair stay off for exactly DB ticks, and then the new side turns on. When DB = 0 the two pins swap on the same tick.
- R8: Control bit 2+p is the polarity of pair p. When set, it inverts the compare result for that pair: both pins in independent mode, and the pair's wanted state in complementary mode. When clear, the high side starts each period on.
- R9: A prescaler value P is written at address 1. While `en` is high, one tick occurs every P+1 clocks. The count and the pins change only on ticks. While `en` is low they hold.
- R10: Reload (address 2) and duty writes take effect only on the tick on which the count returns to 0. Until then the current period keeps its old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for the prescaler and counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0 control, 1 prescaler, 2 reload, 3 dead-band, 4..9 duties) |
| wr_data | input | 16 | Register write data |
| pwm_hi | output | 3 | High-side pin of each pair |
| pwm_lo | output | 3 | Low-side pin of each pair |

## Verification
The bench builds the block with its default parameters: a 12-bit count, 16-bit duties, 8-bit prescaler and dead-band fields, and three pairs. It programs small reload values so that several full periods of both counter shapes fit in a few dozen ticks. Running most scenarios at divide-by-1 makes every clock a tick. This lets the scoreboard compare all six pins on every tick, including dead-band gaps, polarity swaps and a duty write that lands in the middle of a period. One scenario switches to divide-by-4 and measures the pulse width and the period in clocks.

// File: rtl/mcpwm_core.sv
module mcpwm_core #(
  parameter int CW  = 12,
  parameter int DW  = 16,
  parameter int PSW = 8,
  parameter int DBW = 8,
  parameter int NP  = 3,
  parameter int AW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [NP-1:0] pwm_hi,
  output logic [NP-1:0] pwm_lo
);

  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_PSC  = AW'(1);
  localparam logic [AW-1:0] A_REL  = AW'(2);
  localparam logic [AW-1:0] A_DB   = AW'(3);
  localparam int            DBASE  = 4;

  logic           ctr_mode, comp_mode;
  logic [NP-1:0]  pol;
  logic [PSW-1:0] psd, pc;
  logic [DBW-1:0] db;
  logic [CW-1:0]  rel_s, rel_a, cnt, nxt;
  logic           up, nup, tick;
  logic [CW:0]    inc;
  logic [DW-1:0]  dh_s [NP];
  logic [DW-1:0]  dl_s [NP];
  logic [DW-1:0]  dh_a [NP];
  logic [DW-1:0]  dl_a [NP];
  logic [NP-1:0]  cmp_h, cmp_l, want, ih, il, wq;

  // register write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_mode  <= 1'b0;
      comp_mode <= 1'b0;
      pol       <= '0;
      psd       <= '0;
      db        <= '0;
      rel_s     <= '0;
      for (int p = 0; p < NP; p++) begin
        dh_s[p] <= '0;
        dl_s[p] <= '0;
      end
    end else if (wr_en) begin
      if (wr_addr == A_CTRL) begin
        ctr_mode  <= wr_data[0];
        comp_mode <= wr_data[1];
        pol       <= wr_data[2 +: NP];
      end
      if (wr_addr == A_PSC) psd   <= wr_data[PSW-1:0];
      if (wr_addr == A_REL) rel_s <= wr_data[CW-1:0];
      if (wr_addr == A_DB)  db    <= wr_data[DBW-1:0];
      for (int p = 0; p < NP; p++) begin
        if (wr_addr == AW'(DBASE + 2*p))     dh_s[p] <= wr_data;
        if (wr_addr == AW'(DBASE + 2*p + 1)) dl_s[p] <= wr_data;
      end
    end
  end

  // prescaler
  assign tick = en && (pc >= psd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc <= '0;
    else if (tick) pc <= '0;
    else if (en)   pc <= pc + 1'b1;
  end

  // period counter
  assign inc = {1'b0, cnt} + 1'b1;

  always_comb begin
    if (!ctr_mode) begin
      nxt = (inc >= {1'b0, rel_a}) ? '0 : inc[CW-1:0];
      nup = 1'b1;
    end else begin
      if (up && (cnt < rel_a)) nxt = inc[CW-1:0];
      else                     nxt = (cnt == '0) ? '0 : cnt - 1'b1;
      if (nxt == '0)          nup = 1'b1;
      else if (nxt >= rel_a)  nup = 1'b0;
      else                    nup = up;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      up    <= 1'b1;
      rel_a <= '0;
      for (int p = 0; p < NP; p++) begin
        dh_a[p] <= '0;
        dl_a[p] <= '0;
      end
    end else if (tick) begin
      cnt <= nxt;
      up  <= nup;
      if (nxt == '0) begin
        rel_a <= rel_s;
        for (int p = 0; p < NP; p++) begin
          dh_a[p] <= dh_s[p];
          dl_a[p] <= dl_s[p];
        end
      end
    end
  end

  // per-pair compare, polarity, dead-band
  for (genvar p = 0; p < NP; p++) begin : g_pair
    logic [DBW-1:0] dbc;
    logic           quiet;

    assign cmp_h[p] = !dh_a[p][DW-1] && (dh_a[p] > DW'(cnt));
    assign cmp_l[p] = !dl_a[p][DW-1] && (dl_a[p] > DW'(cnt));
    assign want[p]  = cmp_h[p] ^ pol[p];
    assign quiet    = (dbc == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ih[p] <= 1'b0;
        il[p] <= 1'b0;
        wq[p] <= 1'b0;
        dbc   <= '0;
      end else if (tick) begin
        ih[p] <= cmp_h[p] ^ pol[p];
        il[p] <= cmp_l[p] ^ pol[p];
        if (want[p] != wq[p]) begin
          wq[p] <= want[p];
          dbc   <= db;
        end else if (!quiet) begin
          dbc <= dbc - 1'b1;
        end
      end
    end

    assign pwm_hi[p] = comp_mode ? ( wq[p] && quiet) : ih[p];
    assign pwm_lo[p] = comp_mode ? (!wq[p] && quiet) : il[p];
  end

endmodule

// File: rtl/mcpwm_chk.sv
module mcpwm_chk #(
  parameter int CW  = 12,
  parameter int DBW = 8,
  parameter int NP  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic           ctr_mode,
  input logic           comp_mode,
  input logic [DBW-1:0] db,
  input logic [CW-1:0]  cnt,
  input logic [CW-1:0]  rel_a,
  input logic [NP-1:0]  hi,
  input logic [NP-1:0]  lo
);

  AST_CNT_WITHIN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= rel_a); // R3

  AST_ACTIVE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rel_a) |-> cnt == '0); // R10

  AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(cnt)); // R9

  AST_EDGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !ctr_mode |=> (cnt == CW'($past(cnt) + 1'b1)) || (cnt == '0)); // R2

  AST_CENTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && ctr_mode |=> (cnt == CW'($past(cnt) + 1'b1)) ||
                         (cnt == CW'($past(cnt) - 1'b1)) || (cnt == '0)); // R3

  AST_DEADBAND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    comp_mode && $past(comp_mode) && (db != '0) && $stable(db) |->
      ((hi & ~$past(hi) & $past(lo)) == '0) &&
      ((lo & ~$past(lo) & $past(hi)) == '0)); // R7

endmodule

bind mcpwm_core mcpwm_chk #(.CW(CW), .DBW(DBW), .NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ctr_mode(ctr_mode),
  .comp_mode(comp_mode), .db(db), .cnt(cnt), .rel_a(rel_a),
  .hi(pwm_hi), .lo(pwm_lo)
);

// File: tb/sim_mcpwm_core.sv
`timescale 1ns/1ps
module sim_mcpwm_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  pwm_hi, pwm_lo;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;

  typedef struct {
    logic [2:0] hi;
    logic [2:0] lo;
    string      tag;
    int         k;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  mcpwm_core u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo)
  );

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // monitor: pops one expected item per tick
  always @(negedge clk) begin
    if (mon_on && sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (pwm_hi !== e.hi || pwm_lo !== e.lo) begin
        errors++;
        $display("FAIL %s tick %0d actual hi=%b lo=%b expected hi=%b lo=%b",
                 e.tag, e.k, pwm_hi, pwm_lo, e.hi, e.lo);
      end
    end
  end

  task automatic wr(int a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    en = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic int pos_cnt(int s, int r, bit ctr);
    int m;
    if (!ctr) return s % r;
    m = s % (2*r);
    return (m <= r) ? m : 2*r - m;
  endfunction

  function automatic bit on(logic [15:0] d, int c);
    return !d[15] && ($signed(d) > c);
  endfunction

  // driver: configures, predicts every tick, runs
  task automatic play(bit ctr, bit comp, logic [2:0] pol, int rel, int dbv,
                      logic [2:0][15:0] dh, logic [2:0][15:0] dl, int n,
                      bit mid, logic [15:0] dnew, string tag);
    bit w[3];
    int dc[3];
    do_reset();
    wr(0, 16'({pol, comp, ctr}));
    wr(1, 16'd0);
    wr(2, 16'(rel));
    wr(3, 16'(dbv));
    for (int p = 0; p < 3; p++) begin
      wr(4 + 2*p, dh[p]);
      wr(5 + 2*p, dl[p]);
      w[p] = 1'b0; dc[p] = 0;
    end
    for (int k = 1; k <= n; k++) begin
      exp_t e;
      e.tag = tag; e.k = k;
      for (int p = 0; p < 3; p++) begin
        bit ch, cl, ihv, ilv;
        if (k == 1) begin
          ch = 1'b0; cl = 1'b0;
        end else begin
          int c;
          logic [15:0] dd;
          c  = pos_cnt(k-2, rel, ctr);
          dd = (mid && p == 0 && ((k-2) / rel) >= 1) ? dnew : dh[p];
          ch = on(dd, c);
          cl = on(dl[p], c);
        end
        ihv = ch ^ pol[p];
        ilv = cl ^ pol[p];
        if (ihv != w[p]) begin
          w[p] = ihv; dc[p] = dbv;
        end else if (dc[p] != 0) begin
          dc[p]--;
        end
        e.hi[p] = comp ? (w[p] && dc[p] == 0)  : ihv;
        e.lo[p] = comp ? (!w[p] && dc[p] == 0) : ilv;
      end
      sb.push_back(e);
    end
    en = 1'b1;
    @(posedge clk);
    mon_on = 1'b1;
    if (mid) begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      wr(4, dnew);
    end
    wait (sb.size() == 0);
    @(negedge clk);
    en = 1'b0;
    mon_on = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hw, per;
    logic [2:0] fh, fl;
    do_reset();
    // R1: reset state, disabled block stays quiet
    chk(pwm_hi == 3'b000, "R1", "hi after reset", int'(pwm_hi), 0);
    chk(pwm_lo == 3'b000, "R1", "lo after reset", int'(pwm_lo), 0);
    repeat (5) @(negedge clk);
    chk(pwm_hi == 3'b000 && pwm_lo == 3'b000, "R1", "idle pins", int'({pwm_hi, pwm_lo}), 0);

    // R2 R4 R5: edge-aligned independent, full on via duty > and == reload
    play(0, 0, 3'b000, 8, 0, {16'd9, 16'd0, 16'd3}, {16'd8, 16'hFFFE, 16'd5},
         20, 0, 16'd0, "R2/R4/R5");
    // R3 R4: center-aligned, most negative duty
    play(1, 0, 3'b000, 5, 0, {16'd6, 16'h8000, 16'd2}, {16'd0, 16'd5, 16'd1},
         24, 0, 16'd0, "R3/R4");
    // R6 R7 R8: complementary edge, dead-band 2, low duties ignored
    play(0, 1, 3'b010, 10, 2, {16'd11, 16'd7, 16'd4}, {16'd3, 16'd3, 16'd3},
         32, 0, 16'd0, "R6/R7/R8");
    // R7 R8: complementary center, no dead-band
    play(1, 1, 3'b101, 6, 0, {16'd0, 16'd1, 16'd3}, {16'd9, 16'd9, 16'd9},
         26, 0, 16'd0, "R7/R8");
    // R8: independent, all pairs inverted
    play(0, 0, 3'b111, 4, 0, {16'd4, 16'd2, 16'd1}, {16'd0, 16'd3, 16'd2},
         14, 0, 16'd0, "R8");
    // R10: duty written mid-period lands at next wrap
    play(0, 0, 3'b000, 8, 0, {16'd0, 16'd0, 16'd3}, {16'd0, 16'd0, 16'd0},
         30, 1, 16'd6, "R10");

    // R9: divide-by-4, reload 5, duty 2 -> 8 clocks on, 20 clocks period
    do_reset();
    wr(1, 16'd3);
    wr(2, 16'd5);
    wr(4, 16'd2);
    en = 1'b1;
    for (int i = 0; i < 100; i++) begin
      logic pv;
      pv = pwm_hi[0];
      @(negedge clk);
      if (!pv && pwm_hi[0]) break;
    end
    hw = 0;
    while (pwm_hi[0] && hw < 200) begin @(negedge clk); hw++; end
    per = hw;
    while (!pwm_hi[0] && per < 400) begin @(negedge clk); per++; end
    chk(hw == 8, "R9", "high width clocks", hw, 8);
    chk(per == 20, "R9", "period clocks", per, 20);
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    fh = pwm_hi; fl = pwm_lo;
    repeat (12) @(negedge clk);
    chk(pwm_hi == fh && pwm_lo == fl, "R9", "frozen pins", int'({pwm_hi, pwm_lo}),
        int'({fh, fl}));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule